// File: doc/BRIEF.md
# Edge-Encoded Link Transmitter with Quiet-Time Refresh

This block is the digital transmit end of a one-bit isolated channel. It brings an asynchronous logic input into the system clock domain. It then emits a one-cycle symbol strobe on the serial link only when the settled input level changes. Every symbol carries the level the input now holds. A steady input therefore costs no link traffic. The receiving side keeps the last level it was given.

Losing a symbol would leave the receiver stale. To guard against this, a per-channel refresh enable arms a quiet-time watchdog. When no symbol has gone out for the configured quiet interval, the current level is sent again. The quiet interval is 100 µs, converted to clock cycles from the clock frequency. After reset the block sends the input level once, so the far side can take the input state as soon as the transmit side is alive.

Top module: `edge_link_tx`

## Requirements
- R1: Every change of the synchronised input produces exactly one strobe on `sym_valid_o` whose `sym_level_o` is the new level (1 for a rise, 0 for a fall). The strobe appears on the third rising clock edge after the input changes.
- R2: With refresh enabled and a steady input, a strobe carrying the unchanged level goes out when QUIET_CYCLES cycles have passed since the previous strobe, so a steady input yields one strobe every QUIET_CYCLES cycles.
- R3: With refresh disabled and a steady input, no strobe is produced, however long the input stays quiet.
- R4: The quiet count restarts on every strobe, whether edge or refresh. A refresh enable raised after a quiet time of at least QUIET_CYCLES produces a strobe on the next rising edge.
- R5: When an edge and an expiring refresh fall in the same cycle, one strobe is produced, carrying the new edge level. The next refresh follows QUIET_CYCLES cycles after it.
- R6: After reset is released, exactly one start strobe is sent carrying the current input level, on the third rising edge after release, whatever the refresh setting.
- R7: While reset is asserted, `sym_valid_o` and `sym_level_o` are both 0.
- R8: `sym_level_o` holds the level of the most recent strobe between strobes.
- R9: An input that toggles on every clock cycle produces one strobe per cycle, with alternating levels, so no change is dropped at the maximum rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 1 | Asynchronous logic input to convey |
| refresh_en_i | input | 1 | 1 arms the quiet-time refresh for this channel |
| sym_valid_o | output | 1 | One-cycle strobe marking a symbol on the link |
| sym_level_o | output | 1 | Level carried by the current or most recent symbol |

## Verification
Suppose the last-sent level register went wrong. The next input edge would either be missed or produce a strobe with no real change, and a refresh would resend a wrong level; either shows at the ports within three cycles of the stimulus. A faulty quiet counter shows as refresh strobes spaced differently from QUIET_CYCLES, so it is caught by the first refresh interval measured. A wrong priority between edge and refresh shows as a stale level, or as a second strobe, in the exact cycle where the two coincide.

// File: rtl/elt_pkg.sv
package elt_pkg;
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_START   = 2'd1,
    SRC_EDGE    = 2'd2,
    SRC_REFRESH = 2'd3
  } sym_src_e;
endpackage

// File: rtl/elt_sync.sv
module elt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic valid_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      vld_q  <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
      vld_q  <= {vld_q[STAGES-2:0], 1'b1};
    end
  end

  assign q_o     = pipe_q[STAGES-1];
  assign valid_o = vld_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk2
      AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (q_o == $past(d_i, 2))); // R1
    end
  endgenerate
endmodule

// File: rtl/elt_quiet_timer.sv
module elt_quiet_timer #(
  parameter int unsigned QUIET_CYCLES = 25000,
  localparam int CW = $clog2(QUIET_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic arm_i,
  output logic expire_o
);
  localparam logic [CW-1:0] LIMIT = CW'(QUIET_CYCLES);

  logic [CW-1:0] cnt_q;

  // saturates at LIMIT so a late enable fires at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= CW'(1);
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + CW'(1);
  end

  assign expire_o = arm_i && (cnt_q == LIMIT);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT); // R4
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == CW'(1))); // R4
endmodule

// File: rtl/edge_link_tx.sv
module edge_link_tx
  import elt_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ  = 250_000_000,
  parameter int unsigned QUIET_NS     = 100_000,
  parameter int          SYNC_STAGES  = 2,
  parameter int unsigned QUIET_CYCLES =
    int'((64'(CLK_FREQ_HZ) * 64'(QUIET_NS)) / 64'd1_000_000_000)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic refresh_en_i,
  output logic sym_valid_o,
  output logic sym_level_o
);
  logic     sync_lvl, sync_vld;
  logic     primed_q, last_q, valid_q;
  logic     expire;
  logic     start_ev, edge_ev, refresh_ev, sym_ev;
  logic     next_lvl;
  sym_src_e src;

  elt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (data_i),
    .q_o     (sync_lvl),
    .valid_o (sync_vld)
  );

  elt_quiet_timer #(.QUIET_CYCLES(QUIET_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (sym_ev),
    .arm_i     (refresh_en_i && primed_q),
    .expire_o  (expire)
  );

  assign start_ev   = sync_vld && !primed_q;
  assign edge_ev    = primed_q && (sync_lvl != last_q);
  assign refresh_ev = primed_q && expire;

  // start beats edge beats refresh
  always_comb begin
    if (start_ev)        src = SRC_START;
    else if (edge_ev)    src = SRC_EDGE;
    else if (refresh_ev) src = SRC_REFRESH;
    else                 src = SRC_NONE;
  end

  assign sym_ev   = (src != SRC_NONE);
  assign next_lvl = (src == SRC_REFRESH) ? last_q : sync_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      last_q   <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= sym_ev;
      if (sym_ev)   last_q   <= next_lvl;
      if (start_ev) primed_q <= 1'b1;
    end
  end

  assign sym_valid_o = valid_q;
  assign sym_level_o = last_q;

  AST_STEADY_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && $past(primed_q) && !$past(refresh_en_i))
      |-> (sym_level_o != $past(sym_level_o))); // R3
  AST_START_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(primed_q) |-> sym_valid_o); // R6
  AST_MERGE_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_ev && refresh_ev) |=> (sym_valid_o && sym_level_o == $past(sync_lvl))); // R5
  AST_REFRESH_KEEPS_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_ev && !edge_ev) |=> (sym_valid_o && $stable(sym_level_o))); // R2
  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_o |-> $stable(sym_level_o)); // R8
endmodule

// File: tb/edge_link_tx_bench.sv
`timescale 1ns/1ps
module edge_link_tx_bench;
  localparam int Q = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic data_i = 1'b0;
  logic refresh_en_i = 1'b0;
  logic sym_valid_o, sym_level_o;

  always #2 clk = ~clk;

  edge_link_tx #(.QUIET_CYCLES(Q)) u_edge_link_tx (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .data_i       (data_i),
    .refresh_en_i (refresh_en_i),
    .sym_valid_o  (sym_valid_o),
    .sym_level_o  (sym_level_o)
  );

  int cyc = 0;
  int n_sym = 0;
  int last_cyc = -1;
  logic last_lvl = 1'b0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_ni && sym_valid_o) begin
    n_sym    = n_sym + 1;
    last_cyc = cyc;
    last_lvl = sym_level_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {level, gap}
  localparam logic [8:0] VEC [12] = '{
    {1'b1, 8'd4}, {1'b1, 8'd6}, {1'b0, 8'd5}, {1'b1, 8'd4},
    {1'b0, 8'd9}, {1'b0, 8'd4}, {1'b1, 8'd12}, {1'b0, 8'd4},
    {1'b1, 8'd5}, {1'b1, 8'd7}, {1'b0, 8'd6}, {1'b1, 8'd4}
  };

  initial begin
    int base, t0, s0;
    logic prev;
    // R7: reset state
    data_i = 1'b0;
    idle(3);
    check(sym_valid_o == 1'b0 && sym_level_o == 1'b0, "R7", {sym_valid_o, sym_level_o}, 0);

    // R6: start symbol with input high
    data_i = 1'b1;
    idle(1);
    rst_ni = 1'b1;
    t0 = cyc;
    idle(8);
    check(n_sym == 1, "R6 count", n_sym, 1);
    check(last_cyc == t0 + 3, "R6 latency", last_cyc - t0, 3);
    check(last_lvl == 1'b1, "R6 level", last_lvl, 1);
    prev = 1'b1;

    // R1/R3/R8: vector table, refresh off
    foreach (VEC[k]) begin
      s0 = n_sym;
      t0 = cyc;
      data_i = VEC[k][8];
      idle(int'(VEC[k][7:0]));
      check(n_sym - s0 == ((VEC[k][8] != prev) ? 1 : 0), "R1 strobes", n_sym - s0,
            (VEC[k][8] != prev) ? 1 : 0);
      if (VEC[k][8] != prev)
        check(last_cyc == t0 + 3, "R1 latency", last_cyc - t0, 3);
      check(sym_level_o == VEC[k][8], "R8 held level", sym_level_o, VEC[k][8]);
      prev = VEC[k][8];
    end

    // R3: long quiet, refresh off
    s0 = n_sym;
    idle(3 * Q);
    check(n_sym == s0, "R3 silent", n_sym - s0, 0);

    // R4: late enable fires at once; R2: periodic spacing
    t0 = cyc;
    refresh_en_i = 1'b1;
    idle(2);
    check(last_cyc == t0 + 1, "R4 late enable", last_cyc - t0, 1);
    check(last_lvl == prev, "R2 refresh level", last_lvl, prev);
    base = last_cyc;
    s0 = n_sym;
    wait_until(base + Q + 1);
    check(n_sym - s0 == 1 && last_cyc == base + Q, "R2 spacing", last_cyc - base, Q);
    base = last_cyc;
    wait_until(base + Q + 1);
    check(last_cyc == base + Q && last_lvl == prev, "R2 spacing 2", last_cyc - base, Q);
    base = last_cyc;

    // R4: edge restarts quiet count
    wait_until(base + 20);
    data_i = ~prev;
    prev = ~prev;
    t0 = cyc;
    idle(4);
    check(last_cyc == t0 + 3 && last_lvl == prev, "R4 edge strobe", last_cyc - t0, 3);
    base = last_cyc;
    s0 = n_sym;
    wait_until(base + Q - 1);
    check(n_sym == s0, "R4 no early refresh", n_sym - s0, 0);
    wait_until(base + Q + 1);
    check(last_cyc == base + Q, "R4 restart", last_cyc - base, Q);
    base = last_cyc;

    // R5: edge coincides with refresh expiry
    wait_until(base + Q - 3);
    data_i = ~prev;
    prev = ~prev;
    s0 = n_sym;
    wait_until(base + Q + 4);
    check(n_sym - s0 == 1, "R5 single strobe", n_sym - s0, 1);
    check(last_cyc == base + Q && last_lvl == prev, "R5 edge level", last_lvl, prev);
    base = base + Q;
    wait_until(base + Q + 1);
    check(last_cyc == base + Q, "R5 next refresh", last_cyc - base, Q);

    // R9: toggle every cycle
    refresh_en_i = 1'b0;
    idle(2);
    s0 = n_sym;
    for (int i = 0; i < 8; i++) begin
      data_i = ~data_i;
      @(negedge clk);
      if (i >= 3)
        check(sym_valid_o == 1'b1, "R9 strobe per cycle", sym_valid_o, 1);
    end
    idle(5);
    check(n_sym - s0 == 8, "R9 count", n_sym - s0, 8);
    check(last_lvl == data_i, "R9 final level", last_lvl, data_i);

    // R6: reset mid-stream, input low, refresh on
    rst_ni = 1'b0;
    data_i = 1'b0;
    refresh_en_i = 1'b1;
    idle(2);
    check(sym_valid_o == 1'b0 && sym_level_o == 1'b0, "R7 re-reset", {sym_valid_o, sym_level_o}, 0);
    s0 = n_sym;
    rst_ni = 1'b1;
    t0 = cyc;
    idle(6);
    check(n_sym - s0 == 1 && last_cyc == t0 + 3, "R6 restart strobe", last_cyc - t0, 3);
    check(last_lvl == 1'b0, "R6 restart level", last_lvl, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule